// File: doc/BRIEF.md
# TDM Codec Frame Input Decoder

This block sits on the receive side of a codec's time-division multiplexed serial port. It takes one serial data bit per clock, assembles 16-bit words MSB first, and decodes the six slots the codec owns in each frame. The first owned slot is a control word and the second carries write data for the control register file. Every frame performs exactly one register access, a read or a write. The reply to that access (the read value, or the value the register held before a write) is held on a parallel output for the slot 1 output of the next frame.

The remaining four owned slots carry playback samples for two DAC channels. Each channel uses one slot pair as left and right. A channel can run in mono, where the first slot feeds both sides, and in 8-bit mode, where only the upper byte counts. A channel's samples are accepted only when the control word marks them valid and the channel had asked for data before the frame began. Each accepted pair produces a one-clock strobe.

Top module: `tdm_frame_decoder`

## Requirements
- R1: While `rst_n` is low and after its release, every output is zero, no strobe is raised, and all 32 control registers read back as zero.
- R2: Frame slot 0 starts with the bit clocked while `fsync_i` is high, and each slot is 16 bits, MSB first. Owned slots 0..5 are frame slots `own_base_i` to `own_base_i`+5. No word is decoded before the first frame sync or after frame slot 31 until the next sync.
- R3: In the control word (owned slot 0), bit 9 is the DAC2 valid flag, bit 8 the DAC1 valid flag, bit 7 the access type (1 = read, 0 = write), and bits 4:0 the register address. Every register address 0..31 can be accessed.
- R4: For a write, the owned slot 1 word is stored at the addressed register. `reply_o` takes the register's former contents on the clock that samples the last bit of owned slot 1, and holds it until the next access.
- R5: For a read, `reply_o` takes the addressed register's contents at that same point, and the register is left unchanged.
- R6: In stereo mode, DAC1 takes left from owned slot 2 and right from owned slot 3. DAC2 takes left from slot 4 and right from slot 5. The outputs and a one-clock strobe (`dac_stb_o` bit 0 for DAC1, bit 1 for DAC2) change on the clock that samples the last bit of the pair's second slot.
- R7: When a channel's `dac_mono_i` bit is 1, both its left and right outputs take the pair's first slot, and the second slot has no effect.
- R8: When a channel's valid flag is 0, its slots are discarded. There is no strobe, and its outputs keep their previous values.
- R9: A channel's valid flag counts only if its `dac_req_i` bit was 1 on the clock where `fsync_i` started the frame. Otherwise the channel behaves as in R8.
- R10: When a channel's `dac_byte_i` bit is 1, the upper byte of each accepted sample is output in bits 15:8, and bits 7:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | High with the first bit of frame slot 0 |
| sdata_i | input | 1 | Serial data, MSB first |
| own_base_i | input | 5 | Frame slot where owned slot 0 starts |
| dac_req_i | input | 2 | Per-channel data request, latched at frame sync |
| dac_mono_i | input | 2 | Per-channel mono mode |
| dac_byte_i | input | 2 | Per-channel 8-bit sample mode |
| reply_o | output | 16 | Register access reply for next frame's slot 1 |
| dac1_left_o | output | 16 | DAC1 left sample |
| dac1_right_o | output | 16 | DAC1 right sample |
| dac2_left_o | output | 16 | DAC2 left sample |
| dac2_right_o | output | 16 | DAC2 right sample |
| dac_stb_o | output | 2 | One-clock strobe per accepted sample pair |

## Verification
The bench targets the corner cases that a plausible design could get wrong. In a write followed by writes and reads of the same address, the reply must be the former value, so a design that returns the new data shows up at once. Address 31 catches an address decoder that truncates bits. In a frame whose valid flag is set while its request was low, a design that ignores the request would strobe. Mono frames use distinct second slots and 8-bit frames use non-zero low bytes, so a swapped slot or an unmasked byte changes an output. With a base of 16 and junk in slots 0 to 15, a decoder that counts from the sync edge instead of the offset would act on the junk.

// File: rtl/tdm_dec_pkg.sv
package tdm_dec_pkg;
  localparam int WORD_W      = 16;
  localparam int OWNED_SLOTS = 6;
  // control word bit positions (decoded by the far end, so fixed)
  localparam int CW_DAC2_OK  = 9;
  localparam int CW_DAC1_OK  = 8;
  localparam int CW_READ     = 7;
  localparam int CW_ADDR_W   = 5;

  typedef struct packed {
    logic [1:0]           dac_ok;
    logic                 rd;
    logic [CW_ADDR_W-1:0] addr;
  } ctl_t;
endpackage

// File: rtl/frame_tracker.sv
module frame_tracker #(
  parameter int FRAME_SLOTS = 32,
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic [SLOT_W-1:0] base_i,
  output logic              done_o,
  output logic              owned_o,
  output logic [2:0]        rel_o,
  output logic [15:0]       word_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);
  localparam logic [SLOT_W-1:0] ONE_SLOT  = SLOT_W'(1);

  logic [3:0]        bit_q, bit_d, cur_bit;
  logic [SLOT_W-1:0] slot_q, slot_d, cur_slot, rel;
  logic              act_q, act_d, live;
  logic [14:0]       sh_q, sh_d;

  always_comb begin
    live     = fsync_i | act_q;
    cur_bit  = fsync_i ? 4'd0 : bit_q;
    cur_slot = fsync_i ? '0 : slot_q;
    bit_d    = bit_q;
    slot_d   = slot_q;
    act_d    = act_q;
    sh_d     = sh_q;
    if (live) begin
      sh_d  = {sh_q[13:0], sdata_i};
      bit_d = cur_bit + 4'd1;
      act_d = 1'b1;
      slot_d = cur_slot;
      if (cur_bit == 4'hF) begin
        slot_d = cur_slot + ONE_SLOT;
        if (cur_slot == LAST_SLOT) act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
      act_q  <= 1'b0;
      sh_q   <= '0;
    end else begin
      bit_q  <= bit_d;
      slot_q <= slot_d;
      act_q  <= act_d;
      sh_q   <= sh_d;
    end
  end

  assign rel     = cur_slot - base_i;
  assign done_o  = live && (cur_bit == 4'hF);
  assign owned_o = (cur_slot >= base_i) && (rel < SLOT_W'(tdm_dec_pkg::OWNED_SLOTS));
  assign rel_o   = rel[2:0];
  assign word_o  = {sh_q, sdata_i};

  // words complete at most once every 16 clocks
  assert_word_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int REG_COUNT = 32,
  localparam int ADDR_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       reply_o
);
  logic [15:0] mem_q [REG_COUNT];
  logic [15:0] mem_d [REG_COUNT];
  logic [15:0] reply_q, reply_d;

  always_comb begin
    mem_d   = mem_q;
    reply_d = reply_q;
    if (txn_i) begin
      reply_d = mem_q[addr_i];
      if (!rd_i) mem_d[addr_i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reply_q <= '0;
      for (int i = 0; i < REG_COUNT; i++) mem_q[i] <= '0;
    end else if (txn_i) begin
      reply_q <= reply_d;
      mem_q   <= mem_d;
    end
  end

  assign reply_o = reply_q;

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_i && !rd_i) |=> mem_q[$past(addr_i)] == $past(wdata_i));
  assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_i && rd_i) |=> mem_q[$past(addr_i)] == $past(mem_q[addr_i]));
  assert_reply_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_i |=> $stable(reply_o));
endmodule

// File: rtl/dac_pair_capture.sv
module dac_pair_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        first_done_i,
  input  logic        second_done_i,
  input  logic [15:0] word_i,
  input  logic        valid_i,
  input  logic        req_i,
  input  logic        mono_i,
  input  logic        byte_i,
  output logic [15:0] left_o,
  output logic [15:0] right_o,
  output logic        stb_o
);
  logic [15:0] hold_q, hold_d, left_q, left_d, right_q, right_d;
  logic        stb_q, stb_d, take;

  function automatic logic [15:0] trim(input logic [15:0] v, input logic b8);
    return b8 ? {v[15:8], 8'h00} : v;
  endfunction

  always_comb begin
    take    = second_done_i && valid_i && req_i;
    hold_d  = first_done_i ? word_i : hold_q;
    left_d  = left_q;
    right_d = right_q;
    stb_d   = 1'b0;
    if (take) begin
      left_d  = trim(hold_q, byte_i);
      right_d = trim(mono_i ? hold_q : word_i, byte_i);
      stb_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
      stb_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      left_q  <= left_d;
      right_q <= right_d;
      stb_q   <= stb_d;
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign stb_o   = stb_q;

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |=> !stb_o);
  assert_mono_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && $past(mono_i)) |-> left_o == right_o);
  assert_no_stb_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> $past(valid_i));
  assert_no_stb_unreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> $past(req_i));
  assert_byte_low_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && $past(byte_i)) |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

// File: rtl/tdm_frame_decoder.sv
module tdm_frame_decoder #(
  parameter int FRAME_SLOTS = 32,
  parameter int REG_COUNT   = 32,
  localparam int SLOT_W = $clog2(FRAME_SLOTS),
  localparam int ADDR_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic [SLOT_W-1:0] own_base_i,
  input  logic [1:0]        dac_req_i,
  input  logic [1:0]        dac_mono_i,
  input  logic [1:0]        dac_byte_i,
  output logic [15:0]       reply_o,
  output logic [15:0]       dac1_left_o,
  output logic [15:0]       dac1_right_o,
  output logic [15:0]       dac2_left_o,
  output logic [15:0]       dac2_right_o,
  output logic [1:0]        dac_stb_o
);
  import tdm_dec_pkg::*;

  logic        done, owned;
  logic [2:0]  rel;
  logic [15:0] word;
  logic [OWNED_SLOTS-1:0] slot_done;
  ctl_t        ctl_q, ctl_d;
  logic [1:0]  req_q, req_d;
  logic [1:0][15:0] left, right;

  frame_tracker #(.FRAME_SLOTS(FRAME_SLOTS)) u_track (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .sdata_i(sdata_i),
    .base_i(own_base_i), .done_o(done), .owned_o(owned), .rel_o(rel),
    .word_o(word));

  always_comb begin
    for (int k = 0; k < OWNED_SLOTS; k++)
      slot_done[k] = done && owned && (rel == 3'(k));
    ctl_d = ctl_q;
    if (slot_done[0]) begin
      ctl_d.dac_ok = {word[CW_DAC2_OK], word[CW_DAC1_OK]};
      ctl_d.rd     = word[CW_READ];
      ctl_d.addr   = word[CW_ADDR_W-1:0];
    end
    req_d = fsync_i ? dac_req_i : req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      req_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      req_q <= req_d;
    end
  end

  ctl_regfile #(.REG_COUNT(REG_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .txn_i(slot_done[1]), .rd_i(ctl_q.rd),
    .addr_i(ctl_q.addr[ADDR_W-1:0]), .wdata_i(word), .reply_o(reply_o));

  for (genvar g = 0; g < 2; g++) begin : g_dac
    dac_pair_capture u_cap (
      .clk(clk), .rst_n(rst_n),
      .first_done_i(slot_done[2 + 2*g]), .second_done_i(slot_done[3 + 2*g]),
      .word_i(word), .valid_i(ctl_q.dac_ok[g]), .req_i(req_q[g]),
      .mono_i(dac_mono_i[g]), .byte_i(dac_byte_i[g]),
      .left_o(left[g]), .right_o(right[g]), .stb_o(dac_stb_o[g]));
  end

  assign dac1_left_o  = left[0];
  assign dac1_right_o = right[0];
  assign dac2_left_o  = left[1];
  assign dac2_right_o = right[1];

  // register access happens only in the slot after the control word
  assert_one_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done[1] |-> !slot_done[0]);
  assert_stb_after_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_stb_o != 2'b00) |-> $past(done && owned));
endmodule

// File: tb/tdm_frame_decoder_tb.sv
module tdm_frame_decoder_tb;
  logic clk = 1'b0;
  logic rst_n, fsync, sdata;
  logic [4:0] base;
  logic [1:0] req, mono, byte8;
  logic [15:0] reply, d1l, d1r, d2l, d2r;
  logic [1:0] stb;

  always #5 clk = ~clk;

  tdm_frame_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .sdata_i(sdata),
    .own_base_i(base), .dac_req_i(req), .dac_mono_i(mono), .dac_byte_i(byte8),
    .reply_o(reply), .dac1_left_o(d1l), .dac1_right_o(d1r),
    .dac2_left_o(d2l), .dac2_right_o(d2r), .dac_stb_o(stb));

  int vecs = 0, miss = 0;
  bit finished = 0;
  string tag = "R1";

  // behavioural model state
  int          m_regs [32];
  logic [15:0] m_reply, m_ctl, m_hold [2];
  logic [15:0] m_l [2], m_r [2];
  logic [1:0]  m_stb;

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      miss++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    vecs++;
    chk("reply", reply, m_reply);
    chk("dac1_left", d1l, m_l[0]);
    chk("dac1_right", d1r, m_r[0]);
    chk("dac2_left", d2l, m_l[1]);
    chk("dac2_right", d2r, m_r[1]);
    chk("strobe", {14'd0, stb}, {14'd0, m_stb});
  endtask

  function automatic logic [15:0] cw(bit v2, bit v1, bit rd, logic [4:0] a);
    return {6'd0, v2, v1, rd, 2'd0, a};
  endfunction

  function automatic logic [15:0] trim(logic [15:0] v, bit b8);
    return b8 ? {v[15:8], 8'h00} : v;
  endfunction

  // model reaction to the completion of owned slot rel, with word w
  task automatic model(int rel, logic [15:0] w, logic [1:0] rq);
    int ch;
    case (rel)
      0: m_ctl = w;
      1: begin
        m_reply = 16'(m_regs[m_ctl[4:0]]);
        if (m_ctl[7] == 1'b0) m_regs[m_ctl[4:0]] = int'(w);
      end
      2, 4: m_hold[(rel - 2) / 2] = w;
      default: begin
        ch = (rel - 3) / 2;
        if (m_ctl[8 + ch] && rq[ch]) begin
          m_l[ch] = trim(m_hold[ch], byte8[ch]);
          m_r[ch] = trim(mono[ch] ? m_hold[ch] : w, byte8[ch]);
          m_stb[ch] = 1'b1;
        end
      end
    endcase
  endtask

  task automatic frame(string t, logic [4:0] b, logic [1:0] rq, logic [1:0] mo,
                       logic [1:0] by, logic [15:0] w0, logic [15:0] w1,
                       logic [15:0] w2, logic [15:0] w3, logic [15:0] w4,
                       logic [15:0] w5);
    logic [15:0] ws [6];
    ws = '{w0, w1, w2, w3, w4, w5};
    for (int s = 0; s < 32; s++) begin
      int rel = s - int'(b);
      bit own = (rel >= 0) && (rel < 6);
      logic [15:0] wd = own ? ws[rel] : 16'($urandom);
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        compare();
        m_stb = 2'b00;
        tag = t; base = b; req = rq; mono = mo; byte8 = by;
        fsync = (s == 0 && k == 0);
        sdata = wd[15 - k];
        if (own && k == 15) model(rel, wd, rq);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fsync = 0; sdata = 0; base = 0; req = 0; mono = 0; byte8 = 0;
    for (int i = 0; i < 32; i++) m_regs[i] = 0;
    m_reply = 0; m_ctl = 0; m_stb = 0;
    for (int c = 0; c < 2; c++) begin m_hold[c] = 0; m_l[c] = 0; m_r[c] = 0; end
    tag = "R1";
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    // R2: serial junk before any frame sync decodes nothing
    tag = "R2";
    repeat (40) begin @(negedge clk); compare(); sdata = 1'($urandom); end
    // R1: register 5 reads back zero after reset
    frame("R1", 0, 2'b00, 2'b00, 2'b00, cw(0,0,1,5), 16'hFFFF, 16'h1, 16'h2, 16'h3, 16'h4);
    // R6: stereo, both DACs, plus write of 0xBEEF to reg 3
    frame("R6", 0, 2'b11, 2'b00, 2'b00, cw(1,1,0,3), 16'hBEEF, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    // R4: overwrite returns former contents
    frame("R4", 0, 2'b11, 2'b00, 2'b00, cw(0,0,0,3), 16'h1234, 16'h0, 16'h0, 16'h0, 16'h0);
    // R5: reads leave the register untouched
    frame("R5", 0, 2'b00, 2'b00, 2'b00, cw(0,0,1,3), 16'hDEAD, 16'h0, 16'h0, 16'h0, 16'h0);
    frame("R5", 0, 2'b00, 2'b00, 2'b00, cw(0,0,1,3), 16'hCAFE, 16'h0, 16'h0, 16'h0, 16'h0);
    // R3: top address, and control bits routed to the right fields
    frame("R3", 0, 2'b10, 2'b00, 2'b00, cw(1,0,0,31), 16'hA5A5, 16'h7777, 16'h8888, 16'h9999, 16'hAAAA);
    frame("R3", 0, 2'b01, 2'b00, 2'b00, cw(0,1,1,31), 16'h0000, 16'h5151, 16'h6262, 16'h7373, 16'h8484);
    // R7: mono, second slot of each pair differs
    frame("R7", 0, 2'b11, 2'b11, 2'b00, cw(1,1,1,0), 16'h0, 16'hA1A2, 16'hB1B2, 16'hC1C2, 16'hD1D2);
    // R8: valid low with request high
    frame("R8", 0, 2'b11, 2'b00, 2'b00, cw(0,0,1,0), 16'h0, 16'hEEEE, 16'hEEEE, 16'hEEEE, 16'hEEEE);
    // R9: valid high without request
    frame("R9", 0, 2'b00, 2'b00, 2'b00, cw(1,1,1,0), 16'h0, 16'h1357, 16'h2468, 16'h3579, 16'h4680);
    frame("R9", 0, 2'b10, 2'b00, 2'b00, cw(1,1,1,0), 16'h0, 16'h0F0F, 16'hF0F0, 16'h5A5A, 16'hA5A5);
    // R10: 8-bit mode clears low byte
    frame("R10", 0, 2'b11, 2'b01, 2'b11, cw(1,1,1,0), 16'h0, 16'h12AB, 16'h34CD, 16'h56EF, 16'h7801);
    // R2: owned slots start at frame slot 16
    frame("R2", 16, 2'b11, 2'b00, 2'b00, cw(1,1,0,9), 16'h0909, 16'h4321, 16'h8765, 16'hCBA9, 16'h0FED);
    frame("R2", 16, 2'b11, 2'b00, 2'b00, cw(0,0,1,9), 16'h0, 16'h0, 16'h0, 16'h0, 16'h0);
    tag = "R2";
    repeat (20) begin @(negedge clk); compare(); m_stb = 0; fsync = 0; sdata = 1'($urandom); end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule